// File: doc/BRIEF.md
# Two-Mode Hardware Thread Issue Selector

This block decides which of several hardware threads supplies the next instruction to one shared pipeline. Each thread has its own program counter register. Every cycle the block either presents one thread index together with that thread's current PC, or it presents nothing. Fetch, decode and execution sit downstream and are not part of the block.

Two selection policies are available, chosen by a plain mode pin. In interleaved mode the block rotates round-robin over the threads that can issue and passes over any thread that cannot. In switch-on-miss mode it stays with one owner thread. A short stall costs only that cycle. A long-latency stall, such as a second-level cache miss, hands ownership to the next eligible thread after a single bubble cycle.

The issue output is a valid-only stream with no back-pressure. The shared pipeline must accept every beat for which `issue_valid` is high. A pipeline that cannot accept an instruction from a thread expresses this by lowering that thread's ready bit, which takes effect in the same cycle. A separate redirect port loads a new target address into any one thread's PC.

Top module: `thread_issue_selector`

## Requirements
- R1: After reset, thread t's PC holds PC_RST_BASE + t*PC_RST_STRIDE. The selection pointer holds thread 0, so the first interleaved search begins at thread 1 and thread 0 is the first switch-on-miss owner.
- R2: In interleaved mode (`sel_coarse`=0), a thread is eligible when its ready bit is 1 and its long-stall bit is 0. The block issues the first eligible thread found in the order pointer+1, pointer+2, …, pointer, wrapping modulo N_THREADS. The pointer then moves to the issued thread.
- R3: When no thread can issue, `issue_valid` is 0 and every PC keeps its value, except for a redirect load.
- R4: In interleaved mode, when a thread other than the one that issued in the previous interleaved cycle is eligible, the issued thread differs from that previous one.
- R5: In switch-on-miss mode (`sel_coarse`=1), the owner issues in every cycle in which its ready bit is 1 and its long-stall bit is 0, and it remains the owner.
- R6: In switch-on-miss mode, when the owner has ready=0 and long-stall=0 (a short stall), no instruction issues and the owner does not change.
- R7: In switch-on-miss mode, when the owner's long-stall bit is 1, no instruction issues in that cycle. Ownership passes to the first eligible thread in the order owner+1, …, owner+N_THREADS-1. That thread can issue in the next cycle. If no other thread is eligible, the owner is kept.
- R8: Each issue adds PC_STEP (default 4) to the PC of the issuing thread only.
- R9: While `issue_valid` is 1, `issue_pc` equals the issuing thread's PC before the increment.
- R10: When `redir_valid` is 1, the PC of thread `redir_tid` takes `redir_pc` at the next clock edge. This load takes priority over an increment of that same thread in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_coarse | input | 1 | 0 = interleaved mode, 1 = switch-on-miss mode |
| thr_ready | input | N_THREADS | Per-thread ready to issue this cycle |
| thr_long_stall | input | N_THREADS | Per-thread long-latency stall indication |
| redir_valid | input | 1 | Load a PC this cycle |
| redir_tid | input | TID_W | Thread whose PC is loaded |
| redir_pc | input | PC_W | Target address for the load |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Issuing thread (holds the pointer while invalid) |
| issue_pc | output | PC_W | PC of the issuing thread |
| pc_all | output | N_THREADS*PC_W | All thread PCs, thread t at bits [t*PC_W +: PC_W] |

## Verification
The bench builds the block with three threads and a 16-bit PC. A thread count that is not a power of two exercises the modulo wrap of both round-robin searches at a slice index that a power-of-two count would never reach. With three threads, every combination of ready and long-stall bits (64 in all) can be swept several times in each mode, starting from changing pointer positions. A long pseudo-random stretch with mode flips and redirects follows the sweep. Every issue decision and every PC is compared against an arithmetic model of the requirements.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic {
    SEL_INTERLEAVE = 1'b0,
    SEL_ON_MISS    = 1'b1
  } sel_mode_e;

  function automatic int tid_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tis_rr_pick.sv
// Round-robin finder: first set request at base+1, base+2, ... base (mod N).
module tis_rr_pick #(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [TID_W-1:0] base,
  output logic             found,
  output logic [TID_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = base;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(base) + k;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = TID_W'(c);
      end
    end
  end
endmodule

// File: rtl/tis_pc_bank.sv
// Replicated per-thread program counters.
module tis_pc_bank #(
  parameter int          N             = 4,
  parameter int          TID_W         = 2,
  parameter int          PC_W          = 32,
  parameter int unsigned PC_STEP       = 4,
  parameter int unsigned PC_RST_BASE   = 0,
  parameter int unsigned PC_RST_STRIDE = 32'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [TID_W-1:0]  inc_tid,
  input  logic              ld_en,
  input  logic [TID_W-1:0]  ld_tid,
  input  logic [PC_W-1:0]   ld_pc,
  output logic [N*PC_W-1:0] pc_flat
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  for (genvar t = 0; t < N; t++) begin : g_thr
    localparam logic [PC_W-1:0] RST_V = PC_W'(PC_RST_BASE + t * PC_RST_STRIDE);
    logic [PC_W-1:0] pc_q;
    logic            ld_hit, inc_hit;

    assign ld_hit  = ld_en  && (ld_tid  == TID_W'(t));
    assign inc_hit = inc_en && (inc_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n)       pc_q <= RST_V;
      else if (ld_hit)  pc_q <= ld_pc;
      else if (inc_hit) pc_q <= pc_q + STEP_V;
    end

    assign pc_flat[t*PC_W +: PC_W] = pc_q;
  end
endmodule

// File: rtl/tis_sel_ctrl.sv
// Selection policy and pointer / owner register.
module tis_sel_ctrl
  import tis_pkg::*;
#(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sel_mode_e        mode,
  input  logic [N-1:0]     ready,
  input  logic [N-1:0]     long_stall,
  output logic             issue_valid,
  output logic [TID_W-1:0] issue_tid
);
  logic [TID_W-1:0] ptr_q, ptr_d;
  logic [N-1:0]     elig, owner_oh, sw_req;
  logic             fine_found, sw_found;
  logic [TID_W-1:0] fine_idx, sw_idx;

  assign elig = ready & ~long_stall;

  for (genvar t = 0; t < N; t++) begin : g_oh
    assign owner_oh[t] = (ptr_q == TID_W'(t));
  end

  assign sw_req = elig & ~owner_oh;

  tis_rr_pick #(.N(N), .TID_W(TID_W)) u_fine_pick (
    .req(elig), .base(ptr_q), .found(fine_found), .idx(fine_idx)
  );

  tis_rr_pick #(.N(N), .TID_W(TID_W)) u_switch_pick (
    .req(sw_req), .base(ptr_q), .found(sw_found), .idx(sw_idx)
  );

  always_comb begin
    issue_valid = 1'b0;
    issue_tid   = ptr_q;
    ptr_d       = ptr_q;
    if (mode == SEL_INTERLEAVE) begin
      if (fine_found) begin
        issue_valid = 1'b1;
        issue_tid   = fine_idx;
        ptr_d       = fine_idx;
      end
    end else if (|(long_stall & owner_oh)) begin
      if (sw_found) ptr_d = sw_idx;
    end else if (|(ready & owner_oh)) begin
      issue_valid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/thread_issue_selector.sv
module thread_issue_selector
  import tis_pkg::*;
#(
  parameter int          N_THREADS     = 4,
  parameter int          PC_W          = 32,
  parameter int unsigned PC_STEP       = 4,
  parameter int unsigned PC_RST_BASE   = 0,
  parameter int unsigned PC_RST_STRIDE = 32'h1000,
  localparam int         TID_W         = tid_width(N_THREADS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_coarse,
  input  logic [N_THREADS-1:0]      thr_ready,
  input  logic [N_THREADS-1:0]      thr_long_stall,
  input  logic                      redir_valid,
  input  logic [TID_W-1:0]          redir_tid,
  input  logic [PC_W-1:0]           redir_pc,
  output logic                      issue_valid,
  output logic [TID_W-1:0]          issue_tid,
  output logic [PC_W-1:0]           issue_pc,
  output logic [N_THREADS*PC_W-1:0] pc_all
);
  sel_mode_e mode;
  assign mode = sel_coarse ? SEL_ON_MISS : SEL_INTERLEAVE;

  tis_sel_ctrl #(.N(N_THREADS), .TID_W(TID_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .ready      (thr_ready),
    .long_stall (thr_long_stall),
    .issue_valid(issue_valid),
    .issue_tid  (issue_tid)
  );

  tis_pc_bank #(
    .N(N_THREADS), .TID_W(TID_W), .PC_W(PC_W), .PC_STEP(PC_STEP),
    .PC_RST_BASE(PC_RST_BASE), .PC_RST_STRIDE(PC_RST_STRIDE)
  ) u_pcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (issue_valid),
    .inc_tid(issue_tid),
    .ld_en  (redir_valid),
    .ld_tid (redir_tid),
    .ld_pc  (redir_pc),
    .pc_flat(pc_all)
  );

  assign issue_pc = pc_all[issue_tid*PC_W +: PC_W];
endmodule

// File: rtl/tis_chk.sv
module tis_chk #(
  parameter int          N       = 4,
  parameter int          TID_W   = 2,
  parameter int          PC_W    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_coarse,
  input logic [N-1:0]      thr_ready,
  input logic [N-1:0]      thr_long_stall,
  input logic              redir_valid,
  input logic [TID_W-1:0]  redir_tid,
  input logic [PC_W-1:0]   redir_pc,
  input logic              issue_valid,
  input logic [TID_W-1:0]  issue_tid,
  input logic [PC_W-1:0]   issue_pc,
  input logic [N*PC_W-1:0] pc_all
);
  logic              h_iss, h_fine_iss, h_coarse_iss, h_idle, h_red;
  logic [TID_W-1:0]  h_tid, h_red_tid;
  logic [PC_W-1:0]   h_pc, h_red_pc;
  logic [N*PC_W-1:0] h_pc_all;
  logic [N-1:0]      elig, not_prev;
  logic              other_elig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_iss <= 1'b0; h_fine_iss <= 1'b0; h_coarse_iss <= 1'b0;
      h_idle <= 1'b0; h_red <= 1'b0;
      h_tid <= '0; h_red_tid <= '0; h_pc <= '0; h_red_pc <= '0; h_pc_all <= '0;
    end else begin
      h_iss        <= issue_valid;
      h_fine_iss   <= issue_valid && !sel_coarse;
      h_coarse_iss <= issue_valid && sel_coarse;
      h_idle       <= !issue_valid && !redir_valid;
      h_red        <= redir_valid;
      h_tid        <= issue_tid;
      h_pc         <= issue_pc;
      h_red_tid    <= redir_tid;
      h_red_pc     <= redir_pc;
      h_pc_all     <= pc_all;
    end
  end

  assign elig = thr_ready & ~thr_long_stall;
  for (genvar t = 0; t < N; t++) begin : g_np
    assign not_prev[t] = (h_tid != TID_W'(t));
  end
  assign other_elig = |(elig & not_prev);

  // R2
  issue_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (thr_ready[issue_tid] && !thr_long_stall[issue_tid]));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_idle |-> (pc_all == h_pc_all));

  // R4
  fine_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_coarse && issue_valid && h_fine_iss && other_elig) |-> (issue_tid != h_tid));

  // R5
  coarse_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_coarse && issue_valid && h_coarse_iss) |-> (issue_tid == h_tid));

  // R7
  coarse_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_coarse && h_coarse_iss && thr_long_stall[h_tid]) |-> !issue_valid);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_iss && !(h_red && h_red_tid == h_tid)) |->
      (pc_all[h_tid*PC_W +: PC_W] == h_pc + PC_W'(PC_STEP)));

  // R10
  redir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_red |-> (pc_all[h_red_tid*PC_W +: PC_W] == h_red_pc));
endmodule

bind thread_issue_selector tis_chk #(
  .N(N_THREADS), .TID_W(TID_W), .PC_W(PC_W), .PC_STEP(PC_STEP)
) i_tis_chk (
  .clk(clk), .rst_n(rst_n), .sel_coarse(sel_coarse),
  .thr_ready(thr_ready), .thr_long_stall(thr_long_stall),
  .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
  .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
  .pc_all(pc_all)
);

// File: tb/test_thread_issue_selector.sv
module test_thread_issue_selector;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NT = 3;
  localparam int PW = 16;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_coarse = 1'b0;
  logic [NT-1:0] thr_ready = '0;
  logic [NT-1:0] thr_long_stall = '0;
  logic          redir_valid = 1'b0;
  logic [TW-1:0] redir_tid = '0;
  logic [PW-1:0] redir_pc = '0;
  logic          issue_valid;
  logic [TW-1:0] issue_tid;
  logic [PW-1:0] issue_pc;
  logic [NT*PW-1:0] pc_all;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int            m_last;
  logic [PW-1:0] m_pc [NT];
  bit            e_valid;
  int            e_tid;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  thread_issue_selector #(
    .N_THREADS(NT), .PC_W(PW), .PC_STEP(4),
    .PC_RST_BASE(32'h0100), .PC_RST_STRIDE(32'h0100)
  ) i_thread_issue_selector (
    .clk(clk), .rst_n(rst_n), .sel_coarse(sel_coarse),
    .thr_ready(thr_ready), .thr_long_stall(thr_long_stall),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
    .pc_all(pc_all)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pcs(input string req);
    for (int t = 0; t < NT; t++) chk(req, 32'(pc_all[t*PW +: PW]), 32'(m_pc[t]));
  endtask

  // One cycle: drive at negedge, compare combinational outputs, advance model.
  task automatic step(input bit mode, input logic [NT-1:0] rdy, input logic [NT-1:0] stl,
                      input bit rv, input int rt, input logic [PW-1:0] rpc);
    logic [NT-1:0] elig;
    int            nl;
    string         tag;
    @(negedge clk);
    chk_pcs(rv ? "R10" : "R8");
    sel_coarse = mode; thr_ready = rdy; thr_long_stall = stl;
    redir_valid = rv; redir_tid = TW'(rt); redir_pc = rpc;
    #1;
    elig = rdy & ~stl;
    e_valid = 1'b0; e_tid = m_last; nl = m_last;
    if (!mode) begin
      for (int k = 1; k <= NT; k++) begin
        int c;
        c = (m_last + k) % NT;
        if (!e_valid && elig[c]) begin e_valid = 1'b1; e_tid = c; end
      end
      tag = e_valid ? "R2" : "R3";
    end else if (stl[m_last]) begin
      for (int k = NT - 1; k >= 1; k--) begin
        int c;
        c = (m_last + k) % NT;
        if (elig[c]) nl = c;
      end
      tag = "R7";
    end else if (rdy[m_last]) begin
      e_valid = 1'b1; tag = "R5";
    end else begin
      tag = "R6";
    end
    chk(tag, 32'(issue_valid), 32'(e_valid));
    if (e_valid) begin
      chk(tag, 32'(issue_tid), 32'(e_tid));
      chk("R9", 32'(issue_pc), 32'(m_pc[e_tid]));
      m_pc[e_tid] = m_pc[e_tid] + 16'd4;
      m_last = e_tid;
    end
    if (mode && stl[m_last]) m_last = nl;
    if (rv) m_pc[rt] = rpc;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_last = 0;
    for (int t = 0; t < NT; t++) m_pc[t] = PW'(16'h0100 * (t + 1));
    #1;
    // R1: reset PCs and idle output
    chk_pcs("R1");
    chk("R1", 32'(issue_valid), 32'd0);

    // R4 / R1: all ready, interleaved: pointer at 0 gives 1,2,0,1
    step(1'b0, 3'b111, 3'b000, 1'b0, 0, '0); chk("R4", 32'(issue_tid), 32'd1);
    step(1'b0, 3'b111, 3'b000, 1'b0, 0, '0); chk("R4", 32'(issue_tid), 32'd2);
    step(1'b0, 3'b111, 3'b000, 1'b0, 0, '0); chk("R4", 32'(issue_tid), 32'd0);
    step(1'b0, 3'b111, 3'b000, 1'b0, 0, '0); chk("R4", 32'(issue_tid), 32'd1);

    // R7: owner 1 long-stalls, ownership goes to 2 after one bubble
    step(1'b1, 3'b111, 3'b010, 1'b0, 0, '0); chk("R7", 32'(issue_valid), 32'd0);
    step(1'b1, 3'b111, 3'b000, 1'b0, 0, '0); chk("R7", 32'(issue_tid), 32'd2);
    // R6: short stall of owner 2
    step(1'b1, 3'b011, 3'b000, 1'b0, 0, '0); chk("R6", 32'(issue_valid), 32'd0);
    step(1'b1, 3'b111, 3'b000, 1'b0, 0, '0); chk("R6", 32'(issue_tid), 32'd2);
    // R10: redirect the issuing thread in the same cycle
    step(1'b1, 3'b111, 3'b000, 1'b1, 2, 16'h4440);
    step(1'b1, 3'b000, 3'b000, 1'b0, 0, '0);

    // Exhaustive sweep of ready / long-stall combinations, both modes
    for (int m = 0; m < 2; m++)
      for (int rep = 0; rep < 3; rep++)
        for (int c = 0; c < 64; c++)
          step(m[0], NT'(c), NT'(c >> 3), 1'b0, 0, '0);

    // Pseudo-random stretch with mode flips and redirects
    for (int cyc = 0; cyc < 3000; cyc++) begin
      logic [NT-1:0] r, s;
      bit rv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int t = 0; t < NT; t++) begin
        r[t] = lfsr[t] | lfsr[t + 3];
        s[t] = lfsr[t + 6] & lfsr[t + 9] & lfsr[12];
      end
      rv = (cyc % 11) == 5;
      step(((cyc / 150) % 2) == 1, r, s, rv, (cyc / 11) % NT, {lfsr[13:0], 2'b00});
    end

    step(1'b0, 3'b000, 3'b000, 1'b0, 0, '0);
    @(negedge clk);
    chk_pcs("R8");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule